// File: doc/BRIEF.md
# Target-Side Access Firewall

This block sits directly in front of a shared target, such as a memory or a boot ROM, and decides for every incoming request whether it may reach that target. Each request carries an address, a read/write direction, an initiator number, a security-domain tag and a secure bit. The firewall compares these against a table of programmable address windows. A permitted request passes straight through to the target in the same cycle. A refused request never reaches the target. Its write data is dropped, and one cycle later it is answered with an error response.

The window table is programmed through a small configuration port that accepts writes only when they are flagged secure. A control word can freeze the table for good, after which it behaves like fused configuration until the next reset. The first refused request is kept in a violation record, with its address, initiator, domain, secure bit and direction. It also raises a sticky interrupt, which a secure control write clears.

Top module: `xact_firewall`

## Requirements
- R1: After reset every window is disabled, the table is unlocked, the interrupt is low and no response is pending, so the first request of any kind is refused.
- R2: A request whose address falls in no enabled window is refused.
- R3: A permitted request drives `tgt_valid`, `tgt_write`, `tgt_addr` and `tgt_wdata` in its own cycle. On the next cycle `rsp_valid` is 1, `rsp_err` is 0, and `rsp_rdata` holds the target's read data for a read or zero for a write.
- R4: Direction is checked per window: permission bit 1 allows reads and permission bit 2 allows writes.
- R5: The domain mask (permission bits 7:4) must have the bit indexed by `req_dom` set. The initiator mask (permission bits 15:8) must have the bit indexed by `req_init` set.
- R6: A window whose require-secure flag (permission bit 3) is set refuses requests with `req_sec` = 0, and accepts requests with `req_sec` = 1 that otherwise qualify.
- R7: When several enabled windows contain the address, only the lowest-numbered one decides, even if a higher-numbered one would permit the request.
- R8: A refused request leaves `tgt_valid` low and `tgt_wdata` zero. On the next cycle `rsp_valid` = 1, `rsp_err` = 1 and `rsp_rdata` = 0.
- R9: Configuration writes take effect only when `cfg_sec` = 1. Address bit 5 = 0 selects window `cfg_addr[4:2]`, and `cfg_addr[1:0]` selects the field: 0 is the low bound, 1 the high bound, 2 the permissions. Permission bit 0 is the window enable. Writes with `cfg_sec` = 0 change nothing.
- R10: A secure write to control address 0x20 with data bit 0 set locks the table. After that, window writes are ignored and the lock stays set until reset.
- R11: The first refused request while no violation is pending sets `viol_irq` and records its address, initiator, domain, secure bit and direction. Later refusals leave the record unchanged while the interrupt stays set.
- R12: A secure write to 0x20 with data bit 1 set clears the interrupt, and it does so even when the table is locked. If a refusal falls in the same cycle as the clear, the new refusal is recorded and the interrupt stays set.
- R13: A window covers the addresses from its low bound to its high bound, both included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Request address |
| req_wdata | input | 32 | Write data |
| req_init | input | 3 | Initiator number |
| req_dom | input | 2 | Security-domain tag |
| req_sec | input | 1 | Secure bit of the request |
| tgt_valid | output | 1 | Request forwarded to the target |
| tgt_write | output | 1 | Forwarded direction |
| tgt_addr | output | 16 | Forwarded address |
| tgt_wdata | output | 32 | Forwarded write data, zero when refused |
| tgt_rdata | input | 32 | Target read data, same cycle |
| rsp_valid | output | 1 | Response, one cycle after the request |
| rsp_err | output | 1 | Response is an access error |
| rsp_rdata | output | 32 | Read data of the response |
| cfg_valid | input | 1 | Configuration write strobe |
| cfg_sec | input | 1 | Configuration write is secure |
| cfg_addr | input | 6 | Configuration address |
| cfg_wdata | input | 16 | Configuration data |
| cfg_locked | output | 1 | Table frozen |
| viol_irq | output | 1 | Sticky violation interrupt |
| viol_addr | output | 16 | Recorded address |
| viol_init | output | 3 | Recorded initiator |
| viol_dom | output | 2 | Recorded domain |
| viol_sec | output | 1 | Recorded secure bit |
| viol_write | output | 1 | Recorded direction |

## Verification
The collision that matters is a secure interrupt-clear write landing in the same cycle as a newly refused request. The clear would drop the interrupt, while the refusal needs it set. The bench first leaves an older violation pending, then presents the clear and a refused request on the same edge. It then requires the interrupt to remain high, with the record now holding the new request's fields rather than the old ones. A second overlap is covered as well: a window write and a request in the same cycle, where the request must be judged against the table as it stood before that write.

// File: rtl/fw_pkg.sv
package fw_pkg;
  localparam int AW  = 16;
  localparam int IDW = 3;
  localparam int DMW = 2;
  localparam int NI  = 1 << IDW;
  localparam int ND  = 1 << DMW;
  localparam int CDW = AW;

  typedef struct packed {
    logic          en;
    logic          rd;
    logic          wr;
    logic          need_sec;
    logic [ND-1:0] dmask;
    logic [NI-1:0] imask;
    logic [AW-1:0] lo;
    logic [AW-1:0] hi;
  } rule_t;

  typedef struct packed {
    logic           wr;
    logic           sec;
    logic [DMW-1:0] dom;
    logic [IDW-1:0] init;
    logic [AW-1:0]  addr;
  } req_attr_t;

  function automatic logic in_window(input logic [AW-1:0] a,
                                     input logic [AW-1:0] lo,
                                     input logic [AW-1:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

  function automatic logic rule_grants(input rule_t r, input req_attr_t q);
    logic dir_ok;
    dir_ok = q.wr ? r.wr : r.rd;
    return dir_ok && r.dmask[q.dom] && r.imask[q.init] && (!r.need_sec || q.sec);
  endfunction
endpackage

// File: rtl/fw_rule_bank.sv
module fw_rule_bank
  import fw_pkg::*;
#(
  parameter int NREG = 8,
  localparam int RIW = $clog2(NREG),
  localparam int CAW = RIW + 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_valid,
  input  logic            cfg_sec,
  input  logic [CAW-1:0]  cfg_addr,
  input  logic [CDW-1:0]  cfg_wdata,
  output rule_t [NREG-1:0] rules,
  output logic            locked,
  output logic            clr_evt
);
  logic           wr_ok;
  logic           rule_wr_evt;
  logic           ctrl_evt;
  logic           lock_evt;
  logic [RIW-1:0] sel_idx;
  logic [1:0]     sel_fld;

  assign wr_ok       = cfg_valid && cfg_sec;
  assign ctrl_evt    = wr_ok && cfg_addr[CAW-1];
  assign rule_wr_evt = wr_ok && !cfg_addr[CAW-1] && !locked;
  assign lock_evt    = ctrl_evt && cfg_wdata[0];
  assign clr_evt     = ctrl_evt && cfg_wdata[1];
  assign sel_idx     = cfg_addr[RIW+1:2];
  assign sel_fld     = cfg_addr[1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        locked <= 1'b0;
    else if (lock_evt) locked <= 1'b1;
  end

  for (genvar g = 0; g < NREG; g++) begin : g_rule
    rule_t r_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        r_q <= '0;
      end else if (rule_wr_evt && sel_idx == RIW'(g)) begin
        case (sel_fld)
          2'd0: r_q.lo <= cfg_wdata[AW-1:0];
          2'd1: r_q.hi <= cfg_wdata[AW-1:0];
          2'd2: begin
            r_q.en       <= cfg_wdata[0];
            r_q.rd       <= cfg_wdata[1];
            r_q.wr       <= cfg_wdata[2];
            r_q.need_sec <= cfg_wdata[3];
            r_q.dmask    <= cfg_wdata[4 +: ND];
            r_q.imask    <= cfg_wdata[4+ND +: NI];
          end
          default: ;
        endcase
      end
    end
    assign rules[g] = r_q;
  end

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked); // R10
  AST_LOCKED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(rules)); // R10
  AST_NS_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && !cfg_sec) |=> $stable(rules)); // R9
endmodule

// File: rtl/fw_match.sv
module fw_match
  import fw_pkg::*;
#(
  parameter int NREG = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  rule_t [NREG-1:0] rules,
  input  req_attr_t        q,
  output logic [NREG-1:0]  hit_vec,
  output logic [NREG-1:0]  win_vec,
  output logic             any_hit,
  output logic             granted
);
  logic [NREG-1:0] ok_vec;

  for (genvar g = 0; g < NREG; g++) begin : g_cmp
    assign hit_vec[g] = rules[g].en && in_window(q.addr, rules[g].lo, rules[g].hi);
    assign ok_vec[g]  = rule_grants(rules[g], q);
  end

  always_comb begin
    win_vec = '0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        win_vec    = '0;
        win_vec[i] = 1'b1;
      end
    end
  end

  assign any_hit = |hit_vec;
  assign granted = |(win_vec & ok_vec);

  AST_GRANT_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    granted |-> any_hit); // R2
  AST_WIN_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win_vec) && (any_hit == (win_vec != '0))); // R7
endmodule

// File: rtl/fw_viol_log.sv
module fw_viol_log
  import fw_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      deny_evt,
  input  logic      clr_evt,
  input  req_attr_t q,
  output logic      viol_pend,
  output req_attr_t rec
);
  logic capture;
  assign capture = deny_evt && (!viol_pend || clr_evt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      viol_pend <= 1'b0;
      rec       <= '0;
    end else if (capture) begin
      viol_pend <= 1'b1;
      rec       <= q;
    end else if (clr_evt) begin
      viol_pend <= 1'b0;
    end
  end

  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_pend && !clr_evt) |=> viol_pend); // R11
  AST_REC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_pend && !clr_evt) |=> $stable(rec)); // R11
  AST_PEND_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(viol_pend) |-> $past(deny_evt)); // R11
  AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_evt && !deny_evt) |=> !viol_pend); // R12
  AST_CLR_LOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_evt && deny_evt) |=> viol_pend); // R12
endmodule

// File: rtl/xact_firewall.sv
module xact_firewall
  import fw_pkg::*;
#(
  parameter int NREG = 8,
  parameter int DW   = 32,
  localparam int RIW = $clog2(NREG),
  localparam int CAW = RIW + 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  input  logic           req_write,
  input  logic [AW-1:0]  req_addr,
  input  logic [DW-1:0]  req_wdata,
  input  logic [IDW-1:0] req_init,
  input  logic [DMW-1:0] req_dom,
  input  logic           req_sec,
  output logic           tgt_valid,
  output logic           tgt_write,
  output logic [AW-1:0]  tgt_addr,
  output logic [DW-1:0]  tgt_wdata,
  input  logic [DW-1:0]  tgt_rdata,
  output logic           rsp_valid,
  output logic           rsp_err,
  output logic [DW-1:0]  rsp_rdata,
  input  logic           cfg_valid,
  input  logic           cfg_sec,
  input  logic [CAW-1:0] cfg_addr,
  input  logic [CDW-1:0] cfg_wdata,
  output logic           cfg_locked,
  output logic           viol_irq,
  output logic [AW-1:0]  viol_addr,
  output logic [IDW-1:0] viol_init,
  output logic [DMW-1:0] viol_dom,
  output logic           viol_sec,
  output logic           viol_write
);
  rule_t [NREG-1:0] rules;
  req_attr_t        q;
  req_attr_t        rec;
  logic [NREG-1:0]  hit_vec;
  logic [NREG-1:0]  win_vec;
  logic             any_hit;
  logic             granted;
  logic             pass_evt;
  logic             deny_evt;
  logic             clr_evt;

  assign q = '{wr: req_write, sec: req_sec, dom: req_dom, init: req_init, addr: req_addr};

  fw_rule_bank #(.NREG(NREG)) u_bank (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_sec(cfg_sec),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .rules(rules),
    .locked(cfg_locked), .clr_evt(clr_evt)
  );

  fw_match #(.NREG(NREG)) u_match (
    .clk(clk), .rst_n(rst_n), .rules(rules), .q(q), .hit_vec(hit_vec),
    .win_vec(win_vec), .any_hit(any_hit), .granted(granted)
  );

  assign pass_evt = req_valid && granted;
  assign deny_evt = req_valid && !granted;

  fw_viol_log u_log (
    .clk(clk), .rst_n(rst_n), .deny_evt(deny_evt), .clr_evt(clr_evt),
    .q(q), .viol_pend(viol_irq), .rec(rec)
  );

  assign viol_addr  = rec.addr;
  assign viol_init  = rec.init;
  assign viol_dom   = rec.dom;
  assign viol_sec   = rec.sec;
  assign viol_write = rec.wr;

  assign tgt_valid = pass_evt;
  assign tgt_write = req_write;
  assign tgt_addr  = req_addr;
  assign tgt_wdata = pass_evt ? req_wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= deny_evt;
      rsp_rdata <= (pass_evt && !req_write) ? tgt_rdata : '0;
    end
  end

  AST_RSP_TRACKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R3
  AST_TGT_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_valid |-> (req_valid && any_hit)); // R3
  AST_DENY_GIVES_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !tgt_valid) |=> (rsp_err && rsp_valid)); // R8
  AST_ERR_CLEAN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_rdata == '0)); // R8
endmodule

// File: tb/xact_firewall_test.sv
module xact_firewall_test;
  localparam int P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 0, req_write = 0, req_sec = 0;
  logic [15:0] req_addr = 0;
  logic [31:0] req_wdata = 0;
  logic [2:0]  req_init = 0;
  logic [1:0]  req_dom = 0;
  logic        tgt_valid, tgt_write;
  logic [15:0] tgt_addr;
  logic [31:0] tgt_wdata, tgt_rdata;
  logic        rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;
  logic        cfg_valid = 0, cfg_sec = 0;
  logic [5:0]  cfg_addr = 0;
  logic [15:0] cfg_wdata = 0;
  logic        cfg_locked, viol_irq, viol_sec, viol_write;
  logic [15:0] viol_addr;
  logic [2:0]  viol_init;
  logic [1:0]  viol_dom;

  int total = 0;
  int bad = 0;

  logic [15:0] m_lo [8];
  logic [15:0] m_hi [8];
  logic [15:0] m_pm [8];

  always #(P/2) clk = ~clk;
  assign tgt_rdata = {~tgt_addr, tgt_addr};

  xact_firewall uut (.*);

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic model_ok(input logic [15:0] a, input logic wr,
                                    input logic [1:0] d, input logic [2:0] n, input logic s);
    int k = 0;
    while (k < 8) begin
      if (m_pm[k][0] && a >= m_lo[k] && a <= m_hi[k]) begin
        if (wr && !m_pm[k][2]) return 1'b0;
        if (!wr && !m_pm[k][1]) return 1'b0;
        if (!m_pm[k][4 + int'(d)]) return 1'b0;
        if (!m_pm[k][8 + int'(n)]) return 1'b0;
        return s || !m_pm[k][3];
      end
      k++;
    end
    return 1'b0;
  endfunction

  task automatic cfg_wr(input logic sec, input logic [5:0] a, input logic [15:0] d, input logic track);
    @(negedge clk);
    cfg_valid = 1; cfg_sec = sec; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_valid = 0; cfg_sec = 0;
    if (track && sec && !a[5]) begin
      if (a[1:0] == 2'd0) m_lo[a[4:2]] = d;
      if (a[1:0] == 2'd1) m_hi[a[4:2]] = d;
      if (a[1:0] == 2'd2) m_pm[a[4:2]] = d;
    end
  endtask

  task automatic rule(input int i, input logic [15:0] lo, input logic [15:0] hi, input logic [15:0] pm);
    cfg_wr(1, 6'(i*4 + 0), lo, 1);
    cfg_wr(1, 6'(i*4 + 1), hi, 1);
    cfg_wr(1, 6'(i*4 + 2), pm, 1);
  endtask

  task automatic do_req(input string tag, input logic [15:0] a, input logic wr,
                        input logic [1:0] d, input logic [2:0] n, input logic s);
    logic ok;
    logic [31:0] wd;
    ok = model_ok(a, wr, d, n, s);
    wd = {a, 16'h5A00} ^ {29'd0, n};
    @(negedge clk);
    req_valid = 1; req_addr = a; req_write = wr; req_dom = d; req_init = n;
    req_sec = s; req_wdata = wd;
    #(P/4);
    check(tag, 64'(tgt_valid), 64'(ok));
    check({tag, " R8 wdata"}, 64'(tgt_wdata), ok ? 64'(wd) : 64'd0);
    @(posedge clk); #1;
    check(tag, 64'({rsp_valid, rsp_err}), 64'({1'b1, !ok}));
    check({tag, " R3 rdata"}, 64'(rsp_rdata), (ok && !wr) ? 64'({~a, a}) : 64'd0);
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic clr_irq(input logic sec);
    cfg_wr(sec, 6'h20, 16'h0002, 0);
  endtask

  task automatic check_rec(input string tag, input logic [15:0] a, input logic wr,
                           input logic [1:0] d, input logic [2:0] n, input logic s);
    check(tag, 64'({viol_irq, viol_addr, viol_write, viol_dom, viol_init, viol_sec}),
          64'({1'b1, a, wr, d, n, s}));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) begin m_lo[i] = 0; m_hi[i] = 0; m_pm[i] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 reset", 64'({tgt_valid, rsp_valid, viol_irq, cfg_locked}), 64'd0);
    do_req("R1 first request refused", 16'h0000, 0, 0, 0, 1);
    idle();
    check_rec("R11 first record", 16'h0000, 0, 0, 0, 1);
    clr_irq(0);
    check("R12 non-secure clear ignored", 64'(viol_irq), 64'd1);
    clr_irq(1);
    check("R12 secure clear", 64'(viol_irq), 64'd0);

    // window table: perm = {imask[15:8], dmask[7:4], need_sec, wr, rd, en}
    rule(0, 16'h1000, 16'h10FF, 16'hFF1B);
    rule(1, 16'h1000, 16'h1FFF, 16'h0FF7);
    rule(2, 16'h4000, 16'h4000, 16'h81A7);
    rule(3, 16'h8000, 16'h8FFF, 16'hFFF6);

    // targeted checks
    do_req("R6 secure read of secure window", 16'h1010, 0, 0, 0, 1);
    do_req("R6 non-secure read of secure window", 16'h1010, 0, 0, 0, 0);
    do_req("R4 write to read-only window", 16'h1010, 1, 0, 0, 1);
    do_req("R7 lowest window decides", 16'h10FF, 1, 1, 1, 0);
    do_req("R13 upper bound included", 16'h10FF, 0, 0, 5, 1);
    do_req("R13 past upper bound", 16'h1100, 1, 2, 3, 0);
    do_req("R5 domain bit clear", 16'h4000, 0, 0, 0, 0);
    do_req("R5 domain bit set", 16'h4000, 0, 1, 7, 0);
    do_req("R5 initiator bit clear", 16'h4000, 1, 3, 4, 0);
    do_req("R2 disabled window", 16'h8000, 0, 0, 0, 1);
    do_req("R2 no window", 16'h3000, 0, 0, 0, 1);

    // sweep over boundaries and all attribute combinations
    for (int ai = 0; ai < 11; ai++) begin
      logic [15:0] a;
      case (ai)
        0: a = 16'h0FFF; 1: a = 16'h1000; 2: a = 16'h1080; 3: a = 16'h10FF;
        4: a = 16'h1100; 5: a = 16'h1FFF; 6: a = 16'h2000; 7: a = 16'h3FFF;
        8: a = 16'h4000; 9: a = 16'h4001; default: a = 16'h8000;
      endcase
      for (int c = 0; c < 128; c++)
        do_req("sweep R3 R4 R5 R6 R7 R13", a, c[0], c[2:1], c[5:3], c[6]);
    end
    idle();
    clr_irq(1);

    // R9 non-secure window write has no effect
    cfg_wr(0, 6'h0E, 16'hFFF7, 1);
    do_req("R9 non-secure write ignored", 16'h8000, 0, 0, 0, 1);
    idle();
    clr_irq(1);

    // R3 request and window write in the same cycle uses old table
    @(negedge clk);
    cfg_valid = 1; cfg_sec = 1; cfg_addr = 6'h0E; cfg_wdata = 16'hFFF7;
    req_valid = 1; req_addr = 16'h8010; req_write = 0; req_dom = 0; req_init = 0; req_sec = 1;
    #(P/4);
    check("R3 same-cycle write uses old table", 64'(tgt_valid), 64'd0);
    @(negedge clk);
    cfg_valid = 0; req_valid = 0; m_pm[3] = 16'hFFF7;
    do_req("R9 secure write applied", 16'h8010, 0, 0, 0, 1);
    idle();
    clr_irq(1);

    // R11 first refusal kept
    do_req("R11 deny A", 16'h2222, 1, 2, 6, 0);
    do_req("R11 deny B", 16'h3333, 0, 1, 2, 1);
    idle();
    check_rec("R11 record holds first", 16'h2222, 1, 2, 6, 0);

    // R12 clear and refusal in the same cycle
    @(negedge clk);
    cfg_valid = 1; cfg_sec = 1; cfg_addr = 6'h20; cfg_wdata = 16'h0002;
    req_valid = 1; req_addr = 16'h0444; req_write = 0; req_dom = 3; req_init = 5; req_sec = 1;
    @(posedge clk); #1;
    check_rec("R12 collision records new", 16'h0444, 0, 3, 5, 1);
    @(negedge clk);
    cfg_valid = 0; req_valid = 0;

    // R10 lock
    cfg_wr(1, 6'h20, 16'h0001, 0);
    check("R10 locked", 64'(cfg_locked), 64'd1);
    cfg_wr(1, 6'h0E, 16'h0000, 0);
    do_req("R10 locked table unchanged", 16'h8020, 1, 2, 3, 0);
    idle();
    cfg_wr(1, 6'h20, 16'h0000, 0);
    check("R10 lock stays", 64'(cfg_locked), 64'd1);
    clr_irq(1);
    check("R12 clear works when locked", 64'(viol_irq), 64'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule